// File: doc/BRIEF.md
# Double-Buffered Serial Receive Byte Path

This block sits behind a J1850 bus front end that has already decoded the line into symbol events: start-of-frame, data-bit strobes that carry a bit value, and end-of-data. After a start-of-frame, the block shifts data bits into a collecting shifter. Each finished byte goes to a CPU-visible holding register. If that register still holds an unread byte, the finished byte waits instead in a single parking slot. Each move into the holding register can raise a receive interrupt flag.

The CPU reads the holding register with a one-cycle read strobe and may also overwrite it. A read empties the holding register. If a byte is parked at that moment, the read pulls the parked byte in at the same edge, so the read acts as a handshake that pulls the next byte forward. Two sticky status bits report problems: overrun, when a byte is lost, and framing error, when a byte is cut short. A status-read strobe clears both.

Top module: `rx_dbuf_top`

## Requirements
- R1: After reset the holding register reads 0x00, and the hold-full flag, interrupt flag, overrun flag and framing-error flag are all 0.
- R2: Data-bit strobes are ignored until a start-of-frame is seen and after an end-of-data, until the next start-of-frame. An ignored strobe changes no output.
- R3: Bits are taken most-significant first. Exactly 8 accepted strobes form one byte, whose value is the sum of bit i shifted left by 7-i, where i counts strobes from 0.
- R4: A byte that completes while the holding register is empty is written there at the edge of its last strobe and sets hold-full. When the interrupt enable is 1, it also sets the interrupt flag. A CPU read with no move in the same cycle clears the interrupt flag.
- R5: While the interrupt enable is 0, moves into the holding register leave the interrupt flag at 0.
- R6: A byte that completes while the holding register is full is parked. A later CPU read loads the parked byte into the holding register at that edge and keeps hold-full at 1. A read with nothing parked sets hold-full to 0.
- R7: A byte that completes while a byte is already parked (with no read in that cycle) is dropped and sets the sticky overrun flag. The holding and parked bytes are unchanged. A status read clears the flag.
- R8: A CPU read in the same cycle as a byte completion, while a byte is parked, moves the parked byte into the holding register and parks the completing byte, without setting overrun.
- R9: An end-of-data that arrives after 1 to 7 accepted bits discards those bits and sets the sticky framing-error flag. A status read clears the flag.
- R10: A CPU write replaces the holding register contents. It leaves hold-full and the parked byte unchanged.
- R11: A start-of-frame in the middle of a message clears the bit count, the partial bits and any parked byte. The holding register keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame symbol event |
| bit_vld_i | input | 1 | Data-bit strobe |
| bit_val_i | input | 1 | Value of the strobed bit |
| eod_i | input | 1 | End-of-data symbol event |
| cpu_rd_i | input | 1 | CPU reads the holding register (one cycle) |
| cpu_wr_i | input | 1 | CPU writes the holding register |
| cpu_wdata_i | input | 8 | CPU write data |
| stat_rd_i | input | 1 | CPU status read; clears overrun and framing error |
| irq_en_i | input | 1 | Receive interrupt enable |
| cpu_rdata_o | output | 8 | Holding register contents |
| hold_full_o | output | 1 | Holding register has an unread byte |
| irq_o | output | 1 | Receive interrupt flag |
| ovr_o | output | 1 | Sticky overrun flag |
| ferr_o | output | 1 | Sticky framing-error flag |

## Verification
The bench sends all 256 byte values through one frame each and checks each delivered byte against a value it builds from the bits it sent. A design that took the least significant bit first, or closed a byte one strobe early, fails this sweep. The bench then fills both stages and sends a third byte, once alone and once with a read in the completing cycle. A design that checked the read after the overrun test would flag a false overrun or lose the parked byte. Further cases cover strobes outside a frame, an end-of-data cut short, CPU writes while a byte is parked, and a start-of-frame in mid-message. A design that kept stale partial bits, or cleared the holding register on a restart, gives the wrong byte in those cases.

// File: rtl/rx_dbuf_pkg.sv
package rx_dbuf_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_DIRECT,
    ACT_PARK,
    ACT_REFILL,
    ACT_DROP,
    ACT_EMPTY
  } hold_act_e;

  // Chooses what the two-stage buffer does this cycle.
  function automatic hold_act_e pick_act(input logic done, input logic rd,
                                         input logic park_full, input logic hold_full);
    if (rd && park_full)                return ACT_REFILL;
    else if (done && (!hold_full || rd)) return ACT_DIRECT;
    else if (done && !park_full)         return ACT_PARK;
    else if (done)                       return ACT_DROP;
    else if (rd)                         return ACT_EMPTY;
    else                                 return ACT_NONE;
  endfunction
endpackage

// File: rtl/rx_dbuf_assembler.sv
module rx_dbuf_assembler #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              bit_vld_i,
  input  logic              bit_val_i,
  input  logic              eod_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ferr_evt_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  function automatic logic [BYTE_W-1:0] shift_msb(input logic [BYTE_W-1:0] cur, input logic b);
    return {cur[BYTE_W-2:0], b};
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic              active_q;
  logic              bit_take;

  assign bit_take   = active_q && bit_vld_i && !sof_i && !eod_i;
  assign done_o     = bit_take && (cnt_q == CNT_W'(BYTE_W - 1));
  assign byte_o     = shift_msb(shift_q, bit_val_i);
  assign ferr_evt_o = eod_i && !sof_i && active_q && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shift_q  <= '0;
      active_q <= 1'b0;
    end else if (sof_i) begin
      cnt_q    <= '0;
      shift_q  <= '0;
      active_q <= 1'b1;
    end else if (eod_i) begin
      cnt_q    <= '0;
      shift_q  <= '0;
      active_q <= 1'b0;
    end else if (bit_take) begin
      shift_q <= byte_o;
      cnt_q   <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: outside a frame a strobe leaves the shifter alone
  p_idle_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && bit_vld_i && !sof_i) |=> $stable(shift_q) && (cnt_q == '0));
  // R3: the count never passes one byte
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(BYTE_W));
  // R11: a restart always clears the count
  p_sof_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> (cnt_q == '0) && active_q);
endmodule

// File: rtl/rx_dbuf_holdpath.sv
module rx_dbuf_holdpath
  import rx_dbuf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              irq_en_i,
  output logic [BYTE_W-1:0] hold_o,
  output logic              hold_full_o,
  output logic              park_full_o,
  output logic              irq_o,
  output logic              drop_o
);
  logic [BYTE_W-1:0] hold_q, park_q;
  logic              hold_full_q, park_full_q, irq_q;
  logic              park_eff, move;
  hold_act_e         act;

  assign park_eff    = park_full_q && !flush_i;
  assign act         = pick_act(done_i, rd_i, park_eff, hold_full_q);
  assign move        = (act == ACT_DIRECT) || (act == ACT_REFILL);
  assign drop_o      = (act == ACT_DROP);
  assign hold_o      = hold_q;
  assign hold_full_o = hold_full_q;
  assign park_full_o = park_full_q;
  assign irq_o       = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= '0;
      park_q      <= '0;
      hold_full_q <= 1'b0;
      park_full_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      case (act)
        ACT_DIRECT: hold_q <= byte_i;
        ACT_REFILL: hold_q <= park_q;
        default:    if (wr_i) hold_q <= wdata_i;
      endcase
      if (move)                   hold_full_q <= 1'b1;
      else if (act == ACT_EMPTY)  hold_full_q <= 1'b0;
      if (act == ACT_REFILL)      park_full_q <= done_i;
      else if (act == ACT_PARK)   park_full_q <= 1'b1;
      else if (flush_i)           park_full_q <= 1'b0;
      if ((act == ACT_PARK) || ((act == ACT_REFILL) && done_i)) park_q <= byte_i;
      if (move && irq_en_i)       irq_q <= 1'b1;
      else if (rd_i)              irq_q <= 1'b0;
    end
  end

  // R6: a parked byte always has a full holding register ahead of it
  p_park_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    park_full_q |-> hold_full_q);
  // R6: a read with a byte parked leaves the holding register full
  p_refill_keeps_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && park_full_q && !flush_i) |=> hold_full_q);
  // R5: the interrupt flag only rises from an enabled move
  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(irq_en_i));
  // R7: a dropped byte leaves both stages as they were
  p_drop_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_o && !wr_i) |=> $stable(hold_q) && $stable(park_q) && park_full_q);
  // R8: read and completion together keep a byte parked, no drop
  p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && rd_i && park_full_q && !flush_i) |-> !drop_o ##1 park_full_q);
  // R10: a write never changes the full state
  p_write_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !done_i && !rd_i && !flush_i) |=> $stable(hold_full_q) && $stable(park_full_q));
endmodule

// File: rtl/rx_dbuf_top.sv
module rx_dbuf_top #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              bit_vld_i,
  input  logic              bit_val_i,
  input  logic              eod_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [BYTE_W-1:0] cpu_wdata_i,
  input  logic              stat_rd_i,
  input  logic              irq_en_i,
  output logic [BYTE_W-1:0] cpu_rdata_o,
  output logic              hold_full_o,
  output logic              irq_o,
  output logic              ovr_o,
  output logic              ferr_o
);
  logic              byte_done, ferr_evt, drop_evt, park_full;
  logic [BYTE_W-1:0] asm_byte;
  logic              ovr_q, ferr_q;

  rx_dbuf_assembler #(.BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .bit_vld_i(bit_vld_i),
    .bit_val_i(bit_val_i), .eod_i(eod_i), .done_o(byte_done),
    .byte_o(asm_byte), .ferr_evt_o(ferr_evt)
  );

  rx_dbuf_holdpath #(.BYTE_W(BYTE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .flush_i(sof_i), .done_i(byte_done),
    .byte_i(asm_byte), .rd_i(cpu_rd_i), .wr_i(cpu_wr_i), .wdata_i(cpu_wdata_i),
    .irq_en_i(irq_en_i), .hold_o(cpu_rdata_o), .hold_full_o(hold_full_o),
    .park_full_o(park_full), .irq_o(irq_o), .drop_o(drop_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (drop_evt)       ovr_q <= 1'b1;
      else if (stat_rd_i) ovr_q <= 1'b0;
      if (ferr_evt)       ferr_q <= 1'b1;
      else if (stat_rd_i) ferr_q <= 1'b0;
    end
  end

  assign ovr_o  = ovr_q;
  assign ferr_o = ferr_q;

  // R7: a drop always leaves overrun set
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovr_o);
  // R9: a short frame always leaves framing error set
  p_ferr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_evt |=> ferr_o);
  // R11: a restart leaves nothing parked
  p_sof_unparks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> !park_full);
endmodule

// File: tb/rx_dbuf_top_bench.sv
module rx_dbuf_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sof = 0, bvld = 0, bval = 0, eod = 0, rd = 0, wr = 0, srd = 0, ien = 0;
  logic [7:0] wdata = '0, rdata;
  logic       hfull, irq, ovr, ferr;
  int         checks = 0, errors = 0;
  bit         done_flag = 0;

  rx_dbuf_top u_rx_dbuf_top (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .bit_vld_i(bvld), .bit_val_i(bval),
    .eod_i(eod), .cpu_rd_i(rd), .cpu_wr_i(wr), .cpu_wdata_i(wdata),
    .stat_rd_i(srd), .irq_en_i(ien), .cpu_rdata_o(rdata), .hold_full_o(hfull),
    .irq_o(irq), .ovr_o(ovr), .ferr_o(ferr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected byte from bits sent MSB first, built arithmetically.
  function automatic int expect_byte(input logic [7:0] v);
    int acc = 0;
    for (int i = 0; i < 8; i++) acc += int'(v[7-i]) * (1 << (7 - i));
    return acc;
  endfunction

  task automatic pulse_sof(); sof = 1; step(); sof = 0; endtask
  task automatic pulse_eod(); eod = 1; step(); eod = 0; endtask
  task automatic pulse_rd();  rd = 1;  step(); rd = 0;  endtask
  task automatic pulse_srd(); srd = 1; step(); srd = 0; endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      bvld = 1; bval = v[7-i]; step();
    end
    bvld = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    // R1 reset state
    chk("R1 data", rdata, 0); chk("R1 full", hfull, 0); chk("R1 irq", irq, 0);
    chk("R1 ovr", ovr, 0);    chk("R1 ferr", ferr, 0);

    // R2 strobes before any frame are ignored
    send_bits(8'hFF, 8);
    chk("R2 no frame full", hfull, 0); chk("R2 no frame data", rdata, 0);

    // R3/R4 sweep all byte values, interrupt enabled
    ien = 1;
    for (int b = 0; b < 256; b++) begin
      pulse_sof();
      send_bits(8'(b), 8);
      chk("R3 byte value", rdata, expect_byte(8'(b)));
      chk("R4 full", hfull, 1); chk("R4 irq", irq, 1);
      pulse_eod();
      pulse_rd();
      chk("R4 empty after read", hfull, 0); chk("R4 irq cleared", irq, 0);
    end

    // R5 interrupt disabled
    ien = 0;
    pulse_sof(); send_bits(8'h3C, 8);
    chk("R5 full", hfull, 1); chk("R5 irq stays low", irq, 0);
    pulse_rd(); ien = 1;

    // R6/R7 fill both stages then overrun
    send_bits(8'hA1, 8); send_bits(8'hB2, 8);
    chk("R6 hold first", rdata, 8'hA1); chk("R7 no ovr yet", ovr, 0);
    send_bits(8'hC3, 8);
    chk("R7 ovr set", ovr, 1); chk("R7 hold kept", rdata, 8'hA1);
    pulse_rd();
    chk("R6 refill data", rdata, 8'hB2); chk("R6 refill full", hfull, 1);
    pulse_rd();
    chk("R6 empty", hfull, 0); chk("R7 ovr sticky", ovr, 1);
    pulse_srd();
    chk("R7 ovr cleared", ovr, 0);

    // R8 read coincides with completion
    send_bits(8'h11, 8); send_bits(8'h22, 8);
    send_bits(8'h33, 7);
    bvld = 1; bval = 1'b1; rd = 1; step(); bvld = 0; rd = 0;
    chk("R8 hold parked byte", rdata, 8'h22); chk("R8 no ovr", ovr, 0);
    pulse_rd();
    chk("R8 completing byte", rdata, 8'h33); chk("R8 full", hfull, 1);
    pulse_rd();
    chk("R8 empty", hfull, 0);

    // R9 end-of-data with partial byte, R2 bits after end ignored
    send_bits(8'hE0, 3); pulse_eod();
    chk("R9 ferr", ferr, 1); chk("R9 partial not delivered", hfull, 0);
    send_bits(8'h5A, 8);
    chk("R2 after eod ignored", hfull, 0);
    pulse_srd();
    chk("R9 ferr cleared", ferr, 0);

    // R10 CPU write with holding empty, then with a byte parked
    wr = 1; wdata = 8'h5A; step(); wr = 0;
    chk("R10 write data", rdata, 8'h5A); chk("R10 write keeps empty", hfull, 0);
    pulse_sof(); send_bits(8'h71, 8); send_bits(8'h72, 8);
    wr = 1; wdata = 8'h99; step(); wr = 0;
    chk("R10 overwrite", rdata, 8'h99); chk("R10 full kept", hfull, 1);
    pulse_rd();
    chk("R10 parked kept", rdata, 8'h72);
    pulse_rd();

    // R11 restart mid-message: parked byte and partial bits dropped
    pulse_sof(); send_bits(8'h44, 8); send_bits(8'h55, 8); send_bits(8'hF0, 4);
    pulse_sof();
    chk("R11 hold intact", rdata, 8'h44); chk("R11 full intact", hfull, 1);
    send_bits(8'h0F, 8);
    chk("R11 hold still first", rdata, 8'h44);
    pulse_rd();
    chk("R11 fresh byte", rdata, expect_byte(8'h0F)); chk("R11 ovr", ovr, 0);
    pulse_rd();
    chk("R11 parked discarded", hfull, 0);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule